// File: doc/BRIEF.md
# Converter Built-In-Test Monitor

This block produces the single active-low health flag of a tracking angle converter. On every sample strobe it takes digitized amplitude codes for the sine, cosine and reference channels, plus the signed tracking error from the loop. From these it decides whether three fault causes are present: signal lost, reference lost, or the loop has fallen too far behind the input. All three causes drive one flag. The flag is also held asserted from reset until the loop first settles.

Each cause has its own qualification filter. A cause is reported only after it has been seen on a programmable number of back-to-back samples. It drops on the first sample where the condition is gone. The limit for the tracking error is given in LSBs of the selected output resolution, so the raw-count limit follows the resolution select input. A 3-bit cause vector shows which faults are active at the moment.

Top module: `cvt_health_mon`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `bit_n` is 0 and `cause` is 000.
- R2: Loss of signal (cause bit 0) exists on a sample only when `sin_amp` and `cos_amp` are both strictly less than `AMP_TH`. If either one is equal to or above `AMP_TH`, the condition is absent.
- R3: Loss of reference (cause bit 1) exists on a sample when `ref_amp` is strictly less than `AMP_TH`.
- R4: Excess error (cause bit 2) exists on a sample when |`trk_err`| is strictly greater than 100 << (2*(3 − `res_sel`)). The `res_sel` codes 0, 1, 2 and 3 select 10, 12, 14 and 16-bit resolution.
- R5: A cause bit becomes 1 on the clock edge that accepts the `QUAL_N`-th consecutive strobed sample with its condition present. It becomes 0 on the edge that accepts the first strobed sample without the condition. Cycles with `sample_valid` low change neither `cause` nor `bit_n`.
- R6: The cause bits are independent of each other. Bit 0 is loss of signal, bit 1 is loss of reference, and bit 2 is excess error.
- R7: After reset, `bit_n` stays 0 until a strobed sample arrives with |`trk_err`| not above the R4 limit. After that, the hold does not return until the next reset.
- R8: Once the power-up hold has ended, `bit_n` is 0 exactly when any cause bit is 1.
- R9: The most negative `trk_err` code is treated as magnitude 2^(ERR_W−1), with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Strobe: a new sample is present on the data inputs |
| sin_amp | input | AMP_W | Sine channel amplitude code, unsigned |
| cos_amp | input | AMP_W | Cosine channel amplitude code, unsigned |
| ref_amp | input | AMP_W | Reference amplitude code, unsigned |
| trk_err | input | ERR_W | Signed tracking error in raw 16-bit-resolution counts |
| res_sel | input | 2 | Resolution select: 0=10, 1=12, 2=14, 3=16 bits |
| bit_n | output | 1 | Built-in-test flag, active low |
| cause | output | 3 | Active causes: bit0 signal lost, bit1 reference lost, bit2 excess error |

## Verification
A wrong run counter in a qualification filter shows up at the ports on the very next strobe. The matching cause bit then rises one or more samples too early or too late, or fails to drop when the first clean sample arrives. A settle latch that is stuck or slips shows as `bit_n` held low with `cause` at 000, or as `bit_n` high too early, in the cycle right after the first clean sample. Wrong scaling of the error limit or a wrong magnitude shows only when the error sits next to the limit for a given resolution code. For that reason the stimulus keeps errors at the limit, one count on either side of it, and at the most negative code.

// File: rtl/cvt_health_pkg.sv
package cvt_health_pkg;
   // Positions of the fault causes in the cause vector
   localparam int CAUSE_LOS = 0;
   localparam int CAUSE_LOR = 1;
   localparam int CAUSE_ERR = 2;
   localparam int N_CAUSE   = 3;

   // Resolution select: code c gives (RES_MIN + RES_STEP*c) bits
   localparam int RES_SEL_W = 2;
   localparam int RES_CODES = 1 << RES_SEL_W;
   localparam int RES_STEP  = 2;

   typedef logic [N_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/cvt_amp_detect.sv
module cvt_amp_detect #(
   parameter int AMP_W  = 12,
   parameter int AMP_TH = 410
) (
   input  logic [AMP_W-1:0] sin_amp,
   input  logic [AMP_W-1:0] cos_amp,
   input  logic [AMP_W-1:0] ref_amp,
   output logic             los_raw,
   output logic             lor_raw
);
   localparam logic [AMP_W-1:0] TH = AMP_W'(AMP_TH);

   generate
      if (AMP_TH < 1 || AMP_TH >= (1 << AMP_W)) begin : g_bad_th
         $error("cvt_amp_detect: AMP_TH out of range for AMP_W");
      end
   endgenerate

   logic sin_low, cos_low;

   always_comb begin
      sin_low = (sin_amp < TH);
      cos_low = (cos_amp < TH);
      los_raw = sin_low & cos_low;
      lor_raw = (ref_amp < TH);
   end
endmodule

// File: rtl/cvt_err_detect.sv
module cvt_err_detect
   import cvt_health_pkg::*;
#(
   parameter int ERR_W     = 16,
   parameter int ERR_LIMIT = 100
) (
   input  logic signed [ERR_W-1:0]     trk_err,
   input  logic        [RES_SEL_W-1:0] res_sel,
   output logic                        err_raw
);
   localparam int MAG_W     = ERR_W + 1;
   localparam int MAX_SHIFT = RES_STEP * (RES_CODES - 1);

   generate
      if ((ERR_LIMIT << MAX_SHIFT) >= (1 << (ERR_W - 1))) begin : g_bad_lim
         $error("cvt_err_detect: scaled limit does not fit ERR_W");
      end
      if (ERR_LIMIT < 1) begin : g_bad_lim0
         $error("cvt_err_detect: ERR_LIMIT must be positive");
      end
   endgenerate

   logic [MAG_W-1:0] ext, mag, limit;
   logic [3:0]       shamt;

   always_comb begin
      // sign-extend by one bit so the most negative code has a true magnitude
      ext   = {trk_err[ERR_W-1], trk_err};
      mag   = ext[MAG_W-1] ? (~ext + MAG_W'(1)) : ext;
      shamt = 4'(RES_STEP * (RES_CODES - 1 - int'(res_sel)));
      limit = MAG_W'(ERR_LIMIT) << shamt;
      err_raw = (mag > limit);
   end
endmodule

// File: rtl/cvt_qual_filter.sv
module cvt_qual_filter #(
   parameter int QUAL_N = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_valid,
   input  logic cond,
   output logic flag
);
   generate
      if (QUAL_N < 1) begin : g_bad_q
         $error("cvt_qual_filter: QUAL_N must be at least 1");
      end

      if (QUAL_N == 1) begin : g_direct
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            flag_q <= 1'b0;
            else if (sample_valid) flag_q <= cond;
         end
         assign flag = flag_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(QUAL_N + 1);
         localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_N);
         logic [CNT_W-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) run_q <= '0;
            else if (sample_valid) begin
               if (!cond)                run_q <= '0;
               else if (run_q != CNT_MAX) run_q <= run_q + CNT_W'(1);
            end
         end
         assign flag = (run_q == CNT_MAX);
      end
   endgenerate

   // R5: a clean sample clears the cause on the accepting edge
   a_r5_clear_on_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && !cond) |=> !flag);
   // R5: a cause only appears on the edge that accepts a faulty sample
   a_r5_rise_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(sample_valid && cond));
   // R5: no strobe, no change
   a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |=> $stable(flag));
endmodule

// File: rtl/cvt_health_mon.sv
module cvt_health_mon
   import cvt_health_pkg::*;
#(
   parameter int AMP_W     = 12,
   parameter int AMP_TH    = 410,
   parameter int ERR_W     = 16,
   parameter int ERR_LIMIT = 100,
   parameter int QUAL_N    = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sample_valid,
   input  logic [AMP_W-1:0]        sin_amp,
   input  logic [AMP_W-1:0]        cos_amp,
   input  logic [AMP_W-1:0]        ref_amp,
   input  logic signed [ERR_W-1:0] trk_err,
   input  logic [1:0]              res_sel,
   output logic                    bit_n,
   output logic [2:0]              cause
);
   generate
      if (RES_SEL_W != 2) begin : g_bad_sel
         $error("cvt_health_mon: res_sel width mismatch with package");
      end
   endgenerate

   logic       los_raw, lor_raw, err_raw;
   cause_vec_t raw_vec, flag_vec;
   logic       settled_q;

   cvt_amp_detect #(.AMP_W(AMP_W), .AMP_TH(AMP_TH)) u_amp (
      .sin_amp (sin_amp),
      .cos_amp (cos_amp),
      .ref_amp (ref_amp),
      .los_raw (los_raw),
      .lor_raw (lor_raw)
   );

   cvt_err_detect #(.ERR_W(ERR_W), .ERR_LIMIT(ERR_LIMIT)) u_err (
      .trk_err (trk_err),
      .res_sel (res_sel),
      .err_raw (err_raw)
   );

   always_comb begin
      raw_vec            = '0;
      raw_vec[CAUSE_LOS] = los_raw;
      raw_vec[CAUSE_LOR] = lor_raw;
      raw_vec[CAUSE_ERR] = err_raw;
   end

   for (genvar gi = 0; gi < N_CAUSE; gi++) begin : g_qual
      cvt_qual_filter #(.QUAL_N(QUAL_N)) u_q (
         .clk          (clk),
         .rst_n        (rst_n),
         .sample_valid (sample_valid),
         .cond         (raw_vec[gi]),
         .flag         (flag_vec[gi])
      );
   end

   // power-up hold: released by the first sample inside the error limit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        settled_q <= 1'b0;
      else if (sample_valid && !err_raw) settled_q <= 1'b1;
   end

   assign cause = flag_vec;
   assign bit_n = settled_q & ~(|flag_vec);

   // R7: the settle latch never falls back outside reset
   a_r7_settle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      settled_q |=> settled_q);
   // R7: flag held while unsettled
   a_r7_hold_until_settled: assert property (@(posedge clk) disable iff (!rst_n)
      !settled_q |-> !bit_n);
   // R2: a loss-of-signal report starts only after a sample with both channels low
   a_r2_los_both_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause[CAUSE_LOS]) |-> $past(sin_amp < AMP_W'(AMP_TH) && cos_amp < AMP_W'(AMP_TH)));
   // R3: a loss-of-reference report starts only after a low reference sample
   a_r3_lor_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause[CAUSE_LOR]) |-> $past(ref_amp < AMP_W'(AMP_TH)));
   // R8: a reported cause always pulls the flag low
   a_r8_cause_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
      (|cause) |-> !bit_n);
endmodule

// File: tb/tb_cvt_health_mon.sv
module tb_cvt_health_mon;
   localparam int AMP_W = 12;
   localparam int TH    = 410;
   localparam int ERR_W = 16;
   localparam int QN    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_valid = 1'b0;
   logic [AMP_W-1:0] sin_amp = '0, cos_amp = '0, ref_amp = '0;
   logic signed [ERR_W-1:0] trk_err = '0;
   logic [1:0] res_sel = 2'd3;
   logic bit_n;
   logic [2:0] cause;

   int checks = 0, fails = 0;
   bit done = 0;

   // model state
   int m_cnt[3];
   bit m_settled;

   always #4 clk = ~clk;

   cvt_health_mon #(.AMP_W(AMP_W), .AMP_TH(TH), .ERR_W(ERR_W), .ERR_LIMIT(100), .QUAL_N(QN)) dut (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .sin_amp(sin_amp), .cos_amp(cos_amp), .ref_amp(ref_amp),
      .trk_err(trk_err), .res_sel(res_sel), .bit_n(bit_n), .cause(cause));

   function automatic int lim_of(input int rs);
      return 100 << (2 * (3 - rs));
   endfunction

   function automatic bit err_cond(input int e, input int rs);
      int m;
      m = (e < 0) ? -e : e;
      return m > lim_of(rs);
   endfunction

   function automatic logic [2:0] exp_cause();
      logic [2:0] c;
      for (int i = 0; i < 3; i++) c[i] = (m_cnt[i] >= QN);
      return c;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
      m_settled = 0;
   endtask

   task automatic check(input string tag);
      logic [2:0] ec;
      logic eb;
      ec = exp_cause();
      eb = m_settled && (ec == 3'b000);
      checks++;
      if (cause !== ec || bit_n !== eb) begin
         fails++;
         if (cause[0] !== ec[0]) $display("FAIL R2 %s: cause=%b expected %b", tag, cause, ec);
         else if (cause[1] !== ec[1]) $display("FAIL R3 %s: cause=%b expected %b", tag, cause, ec);
         else if (cause[2] !== ec[2]) $display("FAIL R4 %s: cause=%b expected %b", tag, cause, ec);
         else if (!m_settled) $display("FAIL R7 %s: bit_n=%b expected %b", tag, bit_n, eb);
         else $display("FAIL R8 %s: bit_n=%b expected %b", tag, bit_n, eb);
      end
   endtask

   // at negedge: check the state, then apply the next sample and advance the model
   task automatic step(input string tag, input bit v, input int s, input int c,
                       input int r, input int e, input int rs);
      bit cond[3];
      @(negedge clk);
      check(tag);
      sample_valid = v;
      sin_amp = AMP_W'(s); cos_amp = AMP_W'(c); ref_amp = AMP_W'(r);
      trk_err = ERR_W'(e); res_sel = 2'(rs);
      if (v) begin
         cond[0] = (s < TH) && (c < TH);
         cond[1] = (r < TH);
         cond[2] = err_cond(e, rs);
         for (int i = 0; i < 3; i++)
            m_cnt[i] = cond[i] ? ((m_cnt[i] < QN) ? m_cnt[i] + 1 : QN) : 0;
         if (!cond[2]) m_settled = 1;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      sample_valid = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      checks++;
      if (bit_n !== 1'b0 || cause !== 3'b000) begin
         fails++;
         $display("FAIL R1 in reset: bit_n=%b cause=%b expected 0 000", bit_n, cause);
      end
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R1 first cycle after release; R7 hold while error large
      step("R1 post-reset", 0, 2000, 2000, 2000, 0, 3);
      for (int k = 0; k < 5; k++) step("R7 unsettled", 1, 2000, 2000, 2000, 30000, 3);
      step("R7 settle", 1, 2000, 2000, 2000, 100, 3);
      step("R7 settled", 1, 2000, 2000, 2000, 0, 3);
      // R2 boundary: one channel at threshold -> no loss of signal
      for (int k = 0; k < 5; k++) step("R2 cos at TH", 1, TH - 1, TH, 2000, 0, 3);
      for (int k = 0; k < 5; k++) step("R2 both low", 1, TH - 1, 0, 2000, 0, 3);
      // R5 strobe gaps keep state
      for (int k = 0; k < 4; k++) step("R5 gap", 0, 3000, 3000, 3000, 0, 3);
      step("R5 clear", 1, TH, TH, 2000, 0, 3);
      step("R5 after clear", 1, TH, TH, 2000, 0, 3);
      // R3 boundary
      for (int k = 0; k < 4; k++) step("R3 ref at TH", 1, 2000, 2000, TH, 0, 3);
      for (int k = 0; k < 4; k++) step("R3 ref low", 1, 2000, 2000, TH - 1, 0, 3);
      // R4 limits for each resolution, R6 independence
      for (int rs = 0; rs < 4; rs++) begin
         for (int k = 0; k < 4; k++) step("R4 at limit", 1, 2000, 2000, 2000, -lim_of(rs), rs);
         for (int k = 0; k < 4; k++) step("R4 above limit", 1, 2000, 2000, 2000, lim_of(rs) + 1, rs);
         for (int k = 0; k < 4; k++) step("R6 mixed", 1, 0, 0, 2000, -lim_of(rs) - 1, rs);
      end
      // R9 most negative code
      for (int k = 0; k < 4; k++) step("R9 min code", 1, 2000, 2000, 2000, -32768, 3);
      step("R9 clean", 1, 2000, 2000, 2000, 5, 3);
      // R7 again after a new reset
      do_reset();
      for (int k = 0; k < 3; k++) step("R7 re-hold", 1, 2000, 2000, 2000, -30000, 0);
      // random phase
      for (int n = 0; n < 4000; n++) begin
         int rs, lim, s, c, r, e, pick;
         bit v;
         v = ($urandom % 4) != 0;
         rs = $urandom % 4;
         lim = lim_of(rs);
         pick = $urandom % 3;
         s = (pick == 0) ? int'($urandom % 4096) : TH - 2 + int'($urandom % 4);
         pick = $urandom % 3;
         c = (pick == 0) ? int'($urandom % 4096) : TH - 2 + int'($urandom % 4);
         pick = $urandom % 3;
         r = (pick == 0) ? int'($urandom % 4096) : TH - 2 + int'($urandom % 4);
         pick = $urandom % 4;
         case (pick)
            0: e = int'($urandom % 65536) - 32768;
            1: e = int'($urandom % 64) - 32;
            default: e = (($urandom % 2) ? lim : -lim) - 2 + int'($urandom % 5);
         endcase
         if (n == 2000) do_reset();
         step("random", v, s, c, r, e, rs);
      end
      @(negedge clk);
      check("final");
      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(64'd8 * 64'd200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         summary();
         $finish;
      end
   end
endmodule